// File: doc/BRIEF.md
# Banked ROM Mapper with Nibble RAM

This block sits between an 8-bit processor bus with a 16-bit address and an external banked ROM. It turns processor reads into physical ROM addresses and holds a small built-in RAM whose entries are four bits wide. The lowest 16 KiB of processor space always shows ROM bank 0. The next 16 KiB shows a bank picked by a software-written bank register. That bank number is trimmed to the ROM size, which is a power-of-two count of 16 KiB banks.

Control writes land in the lowest 16 KiB. Address bit 8 of the write decides which control register is loaded. One register is the ROM bank number, and a written zero becomes one. The other is a RAM-enable flag, which only one key byte sets. The nibble RAM answers anywhere in the 8 KiB external-RAM window and repeats every 512 bytes. Reads of the ROM windows return the byte the external ROM drives back on `rom_data`. Reads of the RAM window return the nibble, or all ones while the RAM is off. The bus is plain and synchronous: a write strobe is sampled on the rising clock edge, and the read data path is combinational. There is no handshake.

Top module: `mbc_nibble_mapper`

## Requirements
- R1: After reset the bank register holds 1 and the RAM is disabled, so a read at 0x4000–0x7FFF addresses bank 1 and a read at 0xA000–0xBFFF returns 0xFF.
- R2: A read at 0x0000–0x3FFF drives `rom_addr` equal to the processor address (upper bits zero) and returns `rom_data` on `cpu_rdata`.
- R3: A read at 0x4000–0x7FFF drives `rom_addr` = (bank AND (ROM_BANKS−1)) × 0x4000 + address[13:0] and returns `rom_data`; with ROM_BANKS = 4, bank 4 maps to bank 0 and bank 5 to bank 1.
- R4: A write at 0x0000–0x3FFF with address bit 8 = 1 loads the bank register from data[3:0]; data[7:4] are ignored.
- R5: When that written data[3:0] is 0, the bank register becomes 1.
- R6: A write at 0x0000–0x3FFF with address bit 8 = 0 enables the RAM when the data byte is exactly 0x0A and disables it for any other byte; a bank write never changes the enable.
- R7: The RAM holds 512 four-bit entries indexed by address[8:0], so every address in 0xA000–0xBFFF with the same low nine bits reaches the same entry.
- R8: With the RAM enabled, a write in 0xA000–0xBFFF stores data[3:0], and a read returns the stored nibble in bits [3:0] with bits [7:4] zero.
- R9: With the RAM disabled, a read in 0xA000–0xBFFF returns 0xFF and a write there leaves the stored entry unchanged.
- R10: Writes at 0x4000–0x9FFF and 0xC000–0xFFFF change neither the bank nor the enable, and reads at 0x8000–0x9FFF and 0xC000–0xFFFF return 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | Processor address |
| cpu_wdata | input | 8 | Processor write data |
| cpu_we | input | 1 | Write strobe, sampled on the rising edge |
| cpu_rdata | output | 8 | Read data, combinational from `cpu_addr` and state |
| rom_addr | output | $clog2(ROM_BANKS)+14 | Physical ROM byte address |
| rom_data | input | 8 | Byte returned by the external ROM for `rom_addr` |

## Verification
Every piece of state in the block is visible at the ports within the same cycle as a read. A wrong bank value shows up as bad upper bits of `rom_addr` on the first read of the switchable window. A wrong enable flag turns RAM reads into 0xFF, or a stored nibble into a value, on the first access to the RAM window. A bad RAM index or write gating shows up when a mirrored address is read back. The directed tests read back right after each write, so an error is seen one edge after the write that caused it.

// File: rtl/mbc_pkg.sv
package mbc_pkg;
  localparam int BANK_REG_W = 4;
  localparam int NIB_W      = 4;
  localparam int WIN_OFS_W  = 14;
  localparam logic [7:0] ENABLE_KEY = 8'h0A;

  typedef enum logic [1:0] {WIN_ROM0, WIN_ROMX, WIN_RAM, WIN_NONE} win_e;

  function automatic win_e win_of(input logic [15:0] a);
    if (a[15:14] == 2'b00)      return WIN_ROM0;
    else if (a[15:14] == 2'b01) return WIN_ROMX;
    else if (a[15:13] == 3'b101) return WIN_RAM;
    else                        return WIN_NONE;
  endfunction
endpackage

// File: rtl/mbc_ctrl.sv
module mbc_ctrl
  import mbc_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_ctrl,
  input  logic                  sel_bank,
  input  logic [7:0]            wdata,
  output logic [BANK_REG_W-1:0] bank_q,
  output logic                  en_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank_q <= BANK_REG_W'(1);
      en_q   <= 1'b0;
    end else if (wr_ctrl) begin
      if (sel_bank)
        bank_q <= (wdata[BANK_REG_W-1:0] == '0) ? BANK_REG_W'(1) : wdata[BANK_REG_W-1:0];
      else
        en_q <= (wdata == ENABLE_KEY);
    end
  end

  assert_bank_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bank_q != '0);

  assert_bank_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && !sel_bank) |=> $stable(bank_q));

  assert_en_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && sel_bank) |=> $stable(en_q));
endmodule

// File: rtl/mbc_nibram.sv
module mbc_nibram
  import mbc_pkg::*;
#(
  parameter int DEPTH = 512,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    idx,
  input  logic [NIB_W-1:0] wnib,
  output logic [NIB_W-1:0] rnib
);
  logic [NIB_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[idx] <= wnib;
  end

  assign rnib = mem[idx];

  assert_store_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $stable(idx)) |=> (rnib == $past(wnib)));
endmodule

// File: rtl/mbc_rdpath.sv
module mbc_rdpath
  import mbc_pkg::*;
#(
  parameter int ROM_BANKS = 16,
  localparam int BANK_W = $clog2(ROM_BANKS),
  localparam int ROM_AW = BANK_W + WIN_OFS_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  win_e                  win,
  input  logic [WIN_OFS_W-1:0]  ofs,
  input  logic [BANK_REG_W-1:0] bank_q,
  input  logic                  en_q,
  input  logic [NIB_W-1:0]      ram_nib,
  input  logic [7:0]            rom_data,
  output logic [ROM_AW-1:0]     rom_addr,
  output logic [7:0]            rdata
);
  logic [BANK_W-1:0] bank_eff;

  generate
    if (BANK_W <= BANK_REG_W) begin : g_trim
      assign bank_eff = bank_q[BANK_W-1:0];
    end else begin : g_widen
      assign bank_eff = {{(BANK_W-BANK_REG_W){1'b0}}, bank_q};
    end
  endgenerate

  assign rom_addr = {(win == WIN_ROMX) ? bank_eff : BANK_W'(0), ofs};

  always_comb begin
    case (win)
      WIN_ROM0, WIN_ROMX: rdata = rom_data;
      WIN_RAM:            rdata = en_q ? {{(8-NIB_W){1'b0}}, ram_nib} : 8'hFF;
      default:            rdata = 8'hFF;
    endcase
  end

  assert_fixed_bank_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (win == WIN_ROM0) |-> (rom_addr[ROM_AW-1:WIN_OFS_W] == '0));

  assert_ram_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (win == WIN_RAM && !en_q) |-> (rdata == 8'hFF));

  assert_high_nib_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (win == WIN_RAM && en_q) |-> (rdata[7:4] == 4'h0));

  assert_unmapped_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (win == WIN_NONE) |-> (rdata == 8'hFF));
endmodule

// File: rtl/mbc_nibble_mapper.sv
module mbc_nibble_mapper
  import mbc_pkg::*;
#(
  parameter int ROM_BANKS = 16,
  parameter int RAM_DEPTH = 512,
  localparam int BANK_W = $clog2(ROM_BANKS),
  localparam int ROM_AW = BANK_W + WIN_OFS_W,
  localparam int RAM_AW = $clog2(RAM_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       cpu_addr,
  input  logic [7:0]        cpu_wdata,
  input  logic              cpu_we,
  output logic [7:0]        cpu_rdata,
  output logic [ROM_AW-1:0] rom_addr,
  input  logic [7:0]        rom_data
);
  win_e                  win;
  logic [BANK_REG_W-1:0] bank_q;
  logic                  en_q;
  logic [NIB_W-1:0]      ram_nib;
  logic                  wr_ctrl, wr_ram;

  assign win     = win_of(cpu_addr);
  assign wr_ctrl = cpu_we && (win == WIN_ROM0);
  assign wr_ram  = cpu_we && (win == WIN_RAM) && en_q;

  mbc_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_ctrl  (wr_ctrl),
    .sel_bank (cpu_addr[8]),
    .wdata    (cpu_wdata),
    .bank_q   (bank_q),
    .en_q     (en_q)
  );

  mbc_nibram #(.DEPTH(RAM_DEPTH)) u_ram (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_ram),
    .idx   (cpu_addr[RAM_AW-1:0]),
    .wnib  (cpu_wdata[NIB_W-1:0]),
    .rnib  (ram_nib)
  );

  mbc_rdpath #(.ROM_BANKS(ROM_BANKS)) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .win      (win),
    .ofs      (cpu_addr[WIN_OFS_W-1:0]),
    .bank_q   (bank_q),
    .en_q     (en_q),
    .ram_nib  (ram_nib),
    .rom_data (rom_data),
    .rom_addr (rom_addr),
    .rdata    (cpu_rdata)
  );

  assert_quiet_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_we && win != WIN_ROM0 && win != WIN_RAM) |=> ($stable(bank_q) && $stable(en_q)));

  assert_ram_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_we && win == WIN_RAM && !en_q) |=> $stable(ram_nib));
endmodule

// File: tb/mbc_nibble_mapper_tb.sv
module mbc_nibble_mapper_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_we = 1'b0;
  logic [7:0]  rdata_b, rdata_s, rom_data_b, rom_data_s;
  logic [17:0] rom_addr_b;
  logic [15:0] rom_addr_s;
  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] rom_b(input logic [17:0] a);
    return a[7:0] ^ a[17:10];
  endfunction
  function automatic logic [7:0] rom_s(input logic [15:0] a);
    return a[7:0] ^ a[15:8];
  endfunction

  assign rom_data_b = rom_b(rom_addr_b);
  assign rom_data_s = rom_s(rom_addr_s);

  mbc_nibble_mapper dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_we(cpu_we), .cpu_rdata(rdata_b), .rom_addr(rom_addr_b), .rom_data(rom_data_b)
  );

  mbc_nibble_mapper #(.ROM_BANKS(4)) dut_small_i (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_we(cpu_we), .cpu_rdata(rdata_s), .rom_addr(rom_addr_s), .rom_data(rom_data_s)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_we = 1'b1;
    @(negedge clk);
    cpu_we = 1'b0;
  endtask

  task automatic read_expect(input logic [15:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    cpu_addr = a;
    #1;
    check(rdata_b === exp, req, rdata_b, exp);
  endtask

  task automatic rom_expect(input logic [15:0] a, input logic [17:0] exp_addr, input string req);
    @(negedge clk);
    cpu_addr = a;
    #1;
    check(rom_addr_b === exp_addr, req, rom_addr_b, exp_addr);
    check(rdata_b === rom_b(exp_addr), req, rdata_b, rom_b(exp_addr));
  endtask

  task automatic small_expect(input logic [15:0] a, input logic [15:0] exp_addr, input string req);
    @(negedge clk);
    cpu_addr = a;
    #1;
    check(rom_addr_s === exp_addr, req, rom_addr_s, exp_addr);
    check(rdata_s === rom_s(exp_addr), req, rdata_s, rom_s(exp_addr));
  endtask

  task automatic t_reset;
    rom_expect(16'h4123, 18'h04123, "R1 bank after reset");
    read_expect(16'hA000, 8'hFF, "R1 ram off after reset");
  endtask

  task automatic t_fixed;
    rom_expect(16'h0000, 18'h00000, "R2 fixed low");
    rom_expect(16'h1ABC, 18'h01ABC, "R2 fixed mid");
    rom_expect(16'h3FFF, 18'h03FFF, "R2 fixed top");
  endtask

  task automatic t_bank;
    bus_write(16'h0100, 8'h07);
    rom_expect(16'h5555, {4'd7, 14'h1555}, "R4 bank 7");
    bus_write(16'h01FF, 8'hF3);
    rom_expect(16'h4000, {4'd3, 14'h0000}, "R4 upper data ignored");
    bus_write(16'h2100, 8'h00);
    rom_expect(16'h4001, {4'd1, 14'h0001}, "R5 zero becomes one");
    bus_write(16'h0100, 8'h10);
    rom_expect(16'h4002, {4'd1, 14'h0002}, "R5 low nibble zero");
    bus_write(16'h0100, 8'h0F);
    rom_expect(16'h7FFF, 18'h3FFFF, "R3 bank 15 top");
  endtask

  task automatic t_mask;
    bus_write(16'h0100, 8'h05);
    small_expect(16'h4010, 16'h4010, "R3 mask 5 to 1");
    bus_write(16'h0100, 8'h04);
    small_expect(16'h4010, 16'h0010, "R3 mask 4 to 0");
    bus_write(16'h0100, 8'h0B);
    small_expect(16'h7FFF, 16'hFFFF, "R3 mask 11 to 3");
  endtask

  task automatic t_enable;
    bus_write(16'h0000, 8'h0A);
    bus_write(16'hA010, 8'h06);
    read_expect(16'hA010, 8'h06, "R6 key enables");
    bus_write(16'h0000, 8'h1A);
    read_expect(16'hA010, 8'hFF, "R6 other byte disables");
    bus_write(16'h3E00, 8'h0A);
    read_expect(16'hA010, 8'h06, "R6 re-enable via mirror");
    bus_write(16'h0100, 8'h0A);
    rom_expect(16'h4000, {4'd10, 14'h0}, "R4 bank 10");
    read_expect(16'hA010, 8'h06, "R6 bank write keeps enable");
  endtask

  task automatic t_ram;
    bus_write(16'hA000, 8'h5C);
    read_expect(16'hA000, 8'h0C, "R8 low nibble stored");
    read_expect(16'hA200, 8'h0C, "R7 mirror A200");
    read_expect(16'hBE00, 8'h0C, "R7 mirror BE00");
    bus_write(16'hA001, 8'h37);
    read_expect(16'hA001, 8'h07, "R8 odd entry");
    read_expect(16'hA000, 8'h0C, "R7 neighbour intact");
    bus_write(16'hBFFF, 8'hE9);
    read_expect(16'hA1FF, 8'h09, "R7 top mirror");
  endtask

  task automatic t_disabled;
    bus_write(16'h0000, 8'h00);
    bus_write(16'hA000, 8'h03);
    read_expect(16'hA000, 8'hFF, "R9 read when off");
    bus_write(16'h0000, 8'h0A);
    read_expect(16'hA000, 8'h0C, "R9 write when off ignored");
  endtask

  task automatic t_outside;
    bus_write(16'h0100, 8'h06);
    bus_write(16'h4000, 8'h00);
    bus_write(16'h6100, 8'h01);
    bus_write(16'h8000, 8'h00);
    bus_write(16'hC100, 8'h00);
    bus_write(16'hE000, 8'h00);
    rom_expect(16'h4444, {4'd6, 14'h0444}, "R10 bank unchanged");
    read_expect(16'hA000, 8'h0C, "R10 enable unchanged");
    read_expect(16'h8000, 8'hFF, "R10 read 8000");
    read_expect(16'h9FFF, 8'hFF, "R10 read 9FFF");
    read_expect(16'hC000, 8'hFF, "R10 read C000");
    read_expect(16'hFFFF, 8'hFF, "R10 read FFFF");
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_fixed();
    t_bank();
    t_mask();
    t_enable();
    t_ram();
    t_disabled();
    t_outside();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule